// File: doc/BRIEF.md
# Inband Loop Code Detector

This block watches a received T1 bit stream for two repeating inband loopback codes. The actuate code repeats the five bits 00001 and the deactuate code repeats the three bits 001; both are recognised at any phase. Each code has its own tracker. A tracker keeps the most recent counted bits and marks a bit as errored when those bits do not form a rotation of its code. It counts errored bits over a fixed window of counted bits. At the end of each window the tracker's detection flag is set if the count stayed below the error limit and cleared otherwise. Windows follow one another without a gap. At the line rate the default window spans 51200 bits (about 33.16 ms), and the default limit of 512 is a 1/100 error rate.

A bit enters the trackers only when the bit strobe is high. When the stream is frame aligned, the bit flagged as the framing bit is skipped entirely. The actuate status output normally carries the actuate detection flag. When the mode select is high it carries an external PRBS status input instead. A one-cycle change interrupt marks every cycle in which either status output differs from its value in the cycle before.

Top module: `inband_loop_detector`

## Requirements
- R1: While reset is held, and right after it, `act_stat`, `deact_stat` and `chg_irq` are 0.
- R2: After a full window in which the stream repeats 00001 at any phase with fewer than `ERR_LIM` errored bits, `act_stat` is 1 (mode select low).
- R3: After a full window in which the stream repeats 001 at any phase with fewer than `ERR_LIM` errored bits, `deact_stat` is 1.
- R4: A window with `ERR_LIM` or more errored bits clears that code's status at the window's end.
- R5: A status stays at 1 across every following window whose errored-bit count stays below `ERR_LIM`. A detection flag changes only at a window end.
- R6: When `frm_aligned` and `frm_bit` are both high, the bit is neither shifted in nor counted. When `frm_aligned` is low, the same bit is counted like any other.
- R7: `chg_irq` is 1 in exactly those cycles in which `act_stat` or `deact_stat` differs from its value one cycle earlier.
- R8: With `prbs_sel` high, `act_stat` equals `prbs_ok` from one cycle before, whatever the actuate tracker has found.
- R9: A window is `WIN_BITS` counted bits long. Cycles with `bit_en` low do not advance the window or the trackers. A status reflects a window one cycle after the edge that takes the window's last bit.
- R10: A counted bit is errored when the last L counted bits, the new one included, are not a rotation of the code (L = 5 or 3). After reset the bit history is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: a received bit is present this cycle |
| bit_in | input | 1 | Received data bit |
| frm_aligned | input | 1 | Framer reports frame alignment |
| frm_bit | input | 1 | Current bit is the framing bit of its frame |
| prbs_sel | input | 1 | Route `prbs_ok` to the actuate status output |
| prbs_ok | input | 1 | External PRBS status |
| act_stat | output | 1 | Actuate code status (or PRBS status) |
| deact_stat | output | 1 | Deactuate code status |
| chg_irq | output | 1 | Pulse on any change of either status output |

## Verification
Both trackers close their windows on the same counted bit, so one window end can clear the actuate status and set the deactuate status in the same cycle. A PRBS status toggle routed through the mode select can also land on that edge. The bench provokes these cases by switching the streamed code, and by randomising the mode select and the PRBS input around window ends. A reference model with its own bit counts follows every cycle. It expects one interrupt cycle for every cycle in which at least one output moved, whether one output or both changed.

// File: rtl/lbd_pkg.sv
package lbd_pkg;

  // True when the low 'len' bits of hist equal some rotation of the code.
  function automatic logic is_rotation(input logic [7:0] hist,
                                       input logic [7:0] code,
                                       input int len);
    logic [7:0] mask;
    logic [7:0] rot;
    logic       hit;
    mask = '0;
    for (int i = 0; i < 8; i++)
      if (i < len) mask[i] = 1'b1;
    hit = 1'b0;
    for (int r = 0; r < 8; r++) begin
      if (r < len) begin
        rot = ((code << r) | (code >> (len - r))) & mask;
        if ((hist & mask) == rot) hit = 1'b1;
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/lbd_window_timer.sv
module lbd_window_timer #(
  parameter int WIN_BITS = 51200,
  localparam int CW = $clog2(WIN_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_take,
  output logic          win_last,
  output logic [CW-1:0] win_cnt
);

  assign win_last = bit_take && (win_cnt == CW'(WIN_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        win_cnt <= '0;
    else if (win_last) win_cnt <= '0;
    else if (bit_take) win_cnt <= win_cnt + 1'b1;
  end

endmodule

// File: rtl/lbd_code_track.sv
module lbd_code_track
  import lbd_pkg::*;
#(
  parameter int         CODE_LEN = 5,
  parameter logic [7:0] CODE     = 8'h01,
  parameter int         ERR_LIM  = 512,
  localparam int EW = $clog2(ERR_LIM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_take,
  input  logic bit_in,
  input  logic win_last,
  output logic miss,
  output logic det
);

  logic [CODE_LEN-1:0] hist;
  logic [CODE_LEN-1:0] hist_nx;
  logic [EW-1:0]       err_cnt;
  logic [EW-1:0]       err_sum;

  assign hist_nx = {hist[CODE_LEN-2:0], bit_in};
  assign miss    = bit_take && !is_rotation(8'(hist_nx), CODE, CODE_LEN);

  // saturating count of errored bits in the current window
  assign err_sum = (miss && err_cnt != EW'(ERR_LIM)) ? err_cnt + 1'b1 : err_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '0;
      err_cnt <= '0;
      det     <= 1'b0;
    end else begin
      if (bit_take) hist <= hist_nx;
      if (win_last) begin
        det     <= (err_sum < EW'(ERR_LIM));
        err_cnt <= '0;
      end else if (bit_take) begin
        err_cnt <= err_sum;
      end
    end
  end

endmodule

// File: rtl/inband_loop_detector.sv
module inband_loop_detector #(
  parameter int         WIN_BITS   = 51200,
  parameter int         ERR_LIM    = 512,
  parameter int         ACT_LEN    = 5,
  parameter logic [7:0] ACT_CODE   = 8'h01,
  parameter int         DEACT_LEN  = 3,
  parameter logic [7:0] DEACT_CODE = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic frm_aligned,
  input  logic frm_bit,
  input  logic prbs_sel,
  input  logic prbs_ok,
  output logic act_stat,
  output logic deact_stat,
  output logic chg_irq
);

  localparam int CW = $clog2(WIN_BITS);

  logic          frame_skip;
  logic          bit_take;
  logic          win_last;
  logic [CW-1:0] win_cnt;
  logic          win_zero;
  logic          act_miss, deact_miss;
  logic          act_det, deact_det;
  logic          act_nx;

  assign frame_skip = bit_en && frm_aligned && frm_bit;
  assign bit_take   = bit_en && !frame_skip;
  assign win_zero   = (win_cnt == '0);

  lbd_window_timer #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_take(bit_take),
    .win_last(win_last), .win_cnt(win_cnt)
  );

  lbd_code_track #(.CODE_LEN(ACT_LEN), .CODE(ACT_CODE), .ERR_LIM(ERR_LIM)) u_act (
    .clk(clk), .rst_n(rst_n), .bit_take(bit_take), .bit_in(bit_in),
    .win_last(win_last), .miss(act_miss), .det(act_det)
  );

  lbd_code_track #(.CODE_LEN(DEACT_LEN), .CODE(DEACT_CODE), .ERR_LIM(ERR_LIM)) u_deact (
    .clk(clk), .rst_n(rst_n), .bit_take(bit_take), .bit_in(bit_in),
    .win_last(win_last), .miss(deact_miss), .det(deact_det)
  );

  assign act_nx = prbs_sel ? prbs_ok : act_det;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_stat   <= 1'b0;
      deact_stat <= 1'b0;
      chg_irq    <= 1'b0;
    end else begin
      act_stat   <= act_nx;
      deact_stat <= deact_det;
      chg_irq    <= (act_nx != act_stat) || (deact_det != deact_stat);
    end
  end

endmodule

// File: rtl/lbd_checker.sv
module lbd_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic frame_skip,
  input logic win_last,
  input logic win_zero,
  input logic act_miss,
  input logic deact_miss,
  input logic act_det,
  input logic deact_det,
  input logic prbs_sel,
  input logic prbs_ok,
  input logic act_stat,
  input logic deact_stat,
  input logic chg_irq
);

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (chg_irq == ((act_stat != $past(act_stat)) || (deact_stat != $past(deact_stat))))); // R7

  AST_DET_HOLD_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> ($stable(act_det) && $stable(deact_det))); // R5

  AST_PRBS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_sel |=> (act_stat == $past(prbs_ok))); // R8

  AST_FRAME_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_skip |-> (!act_miss && !deact_miss && !win_last)); // R6

  AST_WINDOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> win_zero); // R9

  AST_IDLE_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> (!act_miss && !deact_miss && !win_last)); // R9

endmodule

bind inband_loop_detector lbd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_skip(frame_skip),
  .win_last(win_last), .win_zero(win_zero), .act_miss(act_miss),
  .deact_miss(deact_miss), .act_det(act_det), .deact_det(deact_det),
  .prbs_sel(prbs_sel), .prbs_ok(prbs_ok), .act_stat(act_stat),
  .deact_stat(deact_stat), .chg_irq(chg_irq)
);

// File: tb/sim_inband_loop_detector.sv
module sim_inband_loop_detector;
  localparam int CLK_P = 10;
  localparam int WIN   = 60;
  localparam int LIM   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 0, bit_in = 0, frm_aligned = 0, frm_bit = 0, prbs_sel = 0, prbs_ok = 0;
  logic act_stat, deact_stat, chg_irq;

  always #(CLK_P/2) clk = ~clk;

  inband_loop_detector #(.WIN_BITS(WIN), .ERR_LIM(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .frm_aligned(frm_aligned), .frm_bit(frm_bit), .prbs_sel(prbs_sel),
    .prbs_ok(prbs_ok), .act_stat(act_stat), .deact_stat(deact_stat),
    .chg_irq(chg_irq)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_cnt, m_aerr, m_derr;
  logic [4:0] m_ah;
  logic [2:0] m_dh;
  logic m_adet, m_ddet, m_a, m_d, m_irq;
  int aph = 0, dph = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // a history holds a rotation of 00001 / 001 exactly when it has a single one
  function automatic bit good_hist(input logic [7:0] h);
    return $countones(h) == 1;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_aerr = 0; m_derr = 0; m_ah = '0; m_dh = '0;
    m_adet = 0; m_ddet = 0; m_a = 0; m_d = 0; m_irq = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_en = 0; bit_in = 0; frm_aligned = 0; frm_bit = 0;
    prbs_sel = 0; prbs_ok = 0;
    repeat (3) @(negedge clk);
    chk(act_stat == 0 && deact_stat == 0 && chg_irq == 0, "R1",
        int'({act_stat, deact_stat, chg_irq}), 0);
    model_reset();
    rst_n = 1;
  endtask

  task automatic cyc(input logic en, input logic b, input logic fa,
                     input logic fb, input logic ps, input logic po);
    logic na, nd, ni, am, dm;
    @(negedge clk);
    bit_en = en; bit_in = b; frm_aligned = fa; frm_bit = fb;
    prbs_sel = ps; prbs_ok = po;
    na = ps ? po : m_adet;
    nd = m_ddet;
    ni = (na != m_a) || (nd != m_d);
    if (en && !(fa && fb)) begin
      m_ah = {m_ah[3:0], b};
      m_dh = {m_dh[1:0], b};
      am = !good_hist(8'(m_ah));
      dm = !good_hist(8'(m_dh));
      if (m_cnt == WIN - 1) begin
        m_adet = (m_aerr + int'(am)) < LIM;
        m_ddet = (m_derr + int'(dm)) < LIM;
        m_aerr = 0; m_derr = 0; m_cnt = 0;
      end else begin
        m_aerr += int'(am); m_derr += int'(dm); m_cnt++;
      end
    end
    m_a = na; m_d = nd; m_irq = ni;
    @(posedge clk);
    #1;
    chk(act_stat == m_a, ps ? "R8" : "R2", int'(act_stat), int'(m_a));
    chk(deact_stat == m_d, "R3", int'(deact_stat), int'(m_d));
    chk(chg_irq == m_irq, "R7", int'(chg_irq), int'(m_irq));
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  // which: 0 actuate code, 1 deactuate code, 2 all ones, 3 random bits
  task automatic send_code(input int which, input int nbits, input int en_pct,
                           input bit fa, input int junk_every,
                           input bit ps, input bit po);
    int sent = 0;
    bit jflag = 0;
    while (sent < nbits) begin
      bit en = ($urandom_range(99) < en_pct);
      logic b;
      if (junk_every > 0 && (sent % junk_every) == junk_every - 1 && !jflag) begin
        cyc(1, 1, fa, 1, ps, po);
        jflag = 1;
      end else if (en) begin
        case (which)
          0: b = (aph == 4);
          1: b = (dph == 2);
          2: b = 1'b1;
          default: b = 1'($urandom_range(1));
        endcase
        cyc(1, b, fa, 0, ps, po);
        aph = (aph + 1) % 5;
        dph = (dph + 1) % 3;
        sent++;
        jflag = 0;
      end else begin
        cyc(0, 1'($urandom_range(1)), fa, 0, ps, po);
      end
    end
  endtask

  initial begin
    int unsigned seed = $urandom(32'd4242);
    if (seed == 0) seed = 1;

    do_reset();

    // R10: zero history after reset makes the first four bits errored
    aph = 0;
    send_code(0, WIN, 100, 0, 0, 0, 0);
    idle();
    chk(act_stat == 0, "R10", int'(act_stat), 0);
    send_code(0, WIN, 100, 0, 0, 0, 0);
    idle();
    chk(act_stat == 1, "R2", int'(act_stat), 1);
    chk(deact_stat == 0, "R3", int'(deact_stat), 0);

    // R9: window length counted in strobed bits only
    do_reset();
    aph = 4;
    send_code(0, WIN - 1, 50, 0, 0, 0, 0);
    idle();
    chk(act_stat == 0, "R9", int'(act_stat), 0);
    send_code(0, 1, 100, 0, 0, 0, 0);
    chk(act_stat == 0, "R9", int'(act_stat), 0);
    idle();
    chk(act_stat == 1, "R9", int'(act_stat), 1);

    // R3 / R4: switch to the deactuate code
    dph = 2;
    send_code(1, 2 * WIN, 100, 0, 0, 0, 0);
    idle();
    chk(deact_stat == 1, "R3", int'(deact_stat), 1);
    chk(act_stat == 0, "R4", int'(act_stat), 0);
    send_code(1, 3 * WIN, 70, 0, 0, 0, 0);
    idle();
    chk(deact_stat == 1, "R5", int'(deact_stat), 1);
    send_code(2, 2 * WIN, 100, 0, 0, 0, 0);
    idle();
    chk(deact_stat == 0, "R4", int'(deact_stat), 0);

    // R6: framing bits skipped only while aligned
    do_reset();
    aph = 4;
    send_code(0, 2 * WIN, 100, 1, 7, 0, 0);
    idle();
    chk(act_stat == 1, "R6", int'(act_stat), 1);
    send_code(0, 2 * WIN, 100, 0, 7, 0, 0);
    idle();
    chk(act_stat == 0, "R6", int'(act_stat), 0);

    // R8 / R7: mode select overrides the actuate status
    cyc(0, 0, 0, 0, 1, 1);
    chk(act_stat == 1, "R8", int'(act_stat), 1);
    chk(chg_irq == 1, "R7", int'(chg_irq), 1);
    cyc(0, 0, 0, 0, 1, 1);
    chk(chg_irq == 0, "R7", int'(chg_irq), 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk(act_stat == 0, "R8", int'(act_stat), 0);
    aph = 4;
    send_code(0, 2 * WIN, 100, 0, 0, 1, 0);
    idle();
    chk(act_stat == 1, "R8", int'(act_stat), 1);
    chk(chg_irq == 1, "R7", int'(chg_irq), 1);

    // constrained random segments, checked every cycle against the model
    do_reset();
    for (int s = 0; s < 40; s++) begin
      int which = $urandom_range(3);
      int jk = $urandom_range(3) * 4;
      send_code(which, $urandom_range(150, 30), $urandom_range(100, 40),
                1'($urandom_range(1)), jk,
                1'($urandom_range(3) == 0), 1'($urandom_range(1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule